// File: doc/BRIEF.md
# DS3 Tributary Demultiplexer and Parity Monitor

This block sits behind a DS3 frame synchronizer on the receive path. It takes the serial DS3 line bits, one per enabled clock, with a start-of-frame marker and an out-of-frame flag. It keeps track of where each bit falls in the frame (subframe, block, bit in block) and sends every payload bit to one of seven DS2 tributary outputs. Each tributary has its own one-cycle data-valid strobe. Stuffing is always present, so the stuff bit of each tributary is recognised and dropped.

The same position tracking drives a performance monitor. Even parity is gathered over all payload bits of a frame. In the next frame it is compared with the two received parity bits and with the three received path-parity (CP) bits. The three received far-end block error bits are also examined. Three saturating counters record P mismatches, CP mismatches and far-end block errors, each at most once per frame. A one-cycle error pulse tells the transmit side to send its far-end block error bits as 000. A read-and-clear strobe copies every count into a holding register and zeroes it.

The frame has 7 subframes of 8 blocks. Each block is one overhead bit followed by 7×`TRIB_BITS` payload bits. The frame search itself is done elsewhere.

Top module: `ds3_demux_mon`

## Requirements
- R1: Subframe, block and bit positions count from 0. In each block, bit 0 is overhead. Payload bit k (block position k+1) goes to tributary k mod 7. One cycle after the enabled clock that samples it, `trib_data[t]` holds the bit and `trib_vld` is one-hot with only bit t set. `trib_vld` is never high for more than one tributary.
- R2: In block 7 of subframe m, payload bit k = m is the stuff bit of tributary m. It never raises a strobe. Overhead bits never raise a strobe either.
- R3: The overhead bits of block 0 in subframes 2 and 3 are P bits. Each is compared with the XOR of all payload bits, stuff bits included, of the preceding complete frame. Any mismatch adds one to `p_err_cnt`'s counter for that frame. No P check is made in the first frame after alignment, after a realignment or after out-of-frame.
- R4: The overhead bits of blocks 2, 4 and 6 in subframe 2 are CP bits. They are compared with the same preceding-frame parity, under the same validity rule as R3. Any mismatch adds one CP count for that frame.
- R5: The overhead bits of blocks 2, 4 and 6 in subframe 3 form the far-end block error group. Any value other than 111 adds one far-end count for that frame.
- R6: `err_pulse` is high for exactly one cycle after the clock that samples the second P bit, if a P mismatch occurred. It is likewise high for one cycle after the clock that samples the last CP bit, if a CP mismatch occurred. A frame therefore gives 0, 1 or 2 pulses.
- R7: Each counter stops at 2^`CNT_W`−1 and never wraps.
- R8: On a clock with `rd_clr` high, each count, including an increment from that same clock, is copied to its output register and the counter is set to zero. After reset all outputs are zero.
- R9: While `oof` is high, `trib_vld` stays zero, the counters do not change and the parity history is invalidated. Only a new `sof` re-establishes alignment.
- R10: No strobe or count occurs before the first `sof`. A `sof` on a bit other than the expected frame start restarts the position count at 0 and invalidates the parity history.
- R11: Clocks with `bit_en` low advance nothing and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit present this clock |
| bit_in | input | 1 | Line bit |
| sof | input | 1 | Marks the first bit of a frame |
| oof | input | 1 | Synchronizer reports out-of-frame |
| rd_clr | input | 1 | Copy counts to outputs and clear them |
| trib_data | output | 7 | Last bit delivered to each tributary |
| trib_vld | output | 7 | One-cycle strobe per tributary |
| err_pulse | output | 1 | Request to send far-end error 000 |
| p_err_cnt | output | CNT_W | Held P-parity mismatch count |
| cp_err_cnt | output | CNT_W | Held CP-parity mismatch count |
| febe_cnt | output | CNT_W | Held far-end block error count |

## Verification
On every cycle, the bound checker verifies the following: tributary strobes are one-hot or zero, stuff bits and out-of-frame bits never raise a strobe, counters stay frozen during out-of-frame and never wrap, a counter grows by at most one per cycle, it reads zero after a clear, and error pulses last one cycle. Other behaviour depends on a whole frame or on the frame before it, and only the bench scenarios can show it. This covers which tributary gets each payload bit, whether parity is taken over the preceding frame, the skipped check after alignment, out-of-frame or a realignment, the once-per-frame counting and the saturated readout. The bench covers these with full frames in a small configuration, checking every bit against arithmetically generated expectations.

// File: rtl/ds3dm_pkg.sv
package ds3dm_pkg;

  localparam int NTRIB      = 7;
  localparam int SUBFRAMES  = 7;
  localparam int BLOCKS     = 8;
  localparam int SF_W       = 3;
  localparam int BLK_W      = 3;
  localparam int BIT_W      = 8;
  localparam int LANE_W     = 3;
  localparam int NUM_CNT    = 3;
  localparam int PAR_SF_A   = 2;
  localparam int PAR_SF_B   = 3;
  localparam int CPAR_SF    = 2;
  localparam int FEBE_SF    = 3;
  localparam int LAST_C_BLK = 6;

  typedef enum logic [2:0] {
    SLOT_INFO,
    SLOT_STUFF,
    SLOT_PAR,
    SLOT_CPAR,
    SLOT_FEBE,
    SLOT_OVH
  } slot_e;

  typedef struct packed {
    logic [SF_W-1:0]  sf;
    logic [BLK_W-1:0] blk;
    logic [BIT_W-1:0] pos;
  } frame_pos_t;

  // Role of the bit at a given frame position.
  function automatic slot_e classify(frame_pos_t p);
    int sf_i;
    int blk_i;
    int pos_i;
    sf_i  = int'(p.sf);
    blk_i = int'(p.blk);
    pos_i = int'(p.pos);
    if (pos_i == 0) begin
      if (blk_i == 0)
        return (sf_i == PAR_SF_A || sf_i == PAR_SF_B) ? SLOT_PAR : SLOT_OVH;
      if ((blk_i % 2) == 0) begin
        if (sf_i == CPAR_SF) return SLOT_CPAR;
        if (sf_i == FEBE_SF) return SLOT_FEBE;
      end
      return SLOT_OVH;
    end
    if (blk_i == BLOCKS - 1 && (pos_i - 1) == sf_i) return SLOT_STUFF;
    return SLOT_INFO;
  endfunction

  // Tributary owning a payload bit (bit interleaved).
  function automatic logic [LANE_W-1:0] lane_of(frame_pos_t p);
    int v;
    if (p.pos == '0) return '0;
    v = (int'(p.pos) - 1) % NTRIB;
    return v[LANE_W-1:0];
  endfunction

  // Saturating increment.
  function automatic logic [31:0] sat_step(logic [31:0] cur, logic inc, logic [31:0] top);
    if (inc && cur != top) return cur + 32'd1;
    return cur;
  endfunction

endpackage

// File: rtl/ds3dm_position.sv
module ds3dm_position
  import ds3dm_pkg::*;
#(
  parameter int TRIB_BITS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       sof,
  input  logic       oof,
  output frame_pos_t cur,
  output logic       in_frame,
  output logic       frame_end,
  output logic       realign
);

  localparam int BLK_LEN = 1 + NTRIB * TRIB_BITS;

  frame_pos_t pos_q;
  frame_pos_t nxt;
  logic       have_q;

  assign cur      = sof ? '0 : pos_q;
  assign in_frame = !oof && (sof || have_q);
  assign frame_end = in_frame
                  && cur.sf  == SF_W'(SUBFRAMES - 1)
                  && cur.blk == BLK_W'(BLOCKS - 1)
                  && cur.pos == BIT_W'(BLK_LEN - 1);
  assign realign  = bit_en && sof && have_q && !oof && (pos_q != '0);

  always_comb begin
    nxt = cur;
    if (cur.pos == BIT_W'(BLK_LEN - 1)) begin
      nxt.pos = '0;
      if (cur.blk == BLK_W'(BLOCKS - 1)) begin
        nxt.blk = '0;
        nxt.sf  = (cur.sf == SF_W'(SUBFRAMES - 1)) ? '0 : cur.sf + 1'b1;
      end else begin
        nxt.blk = cur.blk + 1'b1;
      end
    end else begin
      nxt.pos = cur.pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      have_q <= 1'b0;
    end else if (bit_en) begin
      if (oof)      have_q <= 1'b0;
      else if (sof) have_q <= 1'b1;
      if (in_frame) pos_q <= nxt;
    end
  end

endmodule

// File: rtl/ds3dm_demux.sv
module ds3dm_demux
  import ds3dm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  slot_e             kind,
  input  logic [LANE_W-1:0] lane,
  input  logic              bit_in,
  output logic [NTRIB-1:0]  trib_data,
  output logic [NTRIB-1:0]  trib_vld
);

  logic take;
  assign take = step && (kind == SLOT_INFO);

  for (genvar g = 0; g < NTRIB; g++) begin : g_lane
    logic hit;
    assign hit = take && (lane == LANE_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        trib_data[g] <= 1'b0;
        trib_vld[g]  <= 1'b0;
      end else begin
        trib_vld[g] <= hit;
        if (hit) trib_data[g] <= bit_in;
      end
    end
  end

endmodule

// File: rtl/ds3dm_parity_mon.sv
module ds3dm_parity_mon
  import ds3dm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       oof,
  input  logic       realign,
  input  logic       frame_end,
  input  slot_e      kind,
  input  frame_pos_t cur,
  input  logic       bit_in,
  output logic       p_hit,
  output logic       cp_hit,
  output logic       febe_hit,
  output logic       err_pulse
);

  logic acc_q, prev_par_q, prev_ok_q;
  logic p_bad_q, cp_bad_q, febe_bad_q;
  logic frame_start;
  logic acc_base, acc_n;
  logic p_base, cp_base, febe_base;
  logic p_mis, cp_mis, febe_mis;
  logic is_payload;

  assign frame_start = step && (cur == '0);
  assign is_payload  = (kind == SLOT_INFO) || (kind == SLOT_STUFF);
  assign acc_base    = frame_start ? 1'b0 : acc_q;
  assign acc_n       = acc_base ^ (bit_in & is_payload);
  assign p_base      = frame_start ? 1'b0 : p_bad_q;
  assign cp_base     = frame_start ? 1'b0 : cp_bad_q;
  assign febe_base   = frame_start ? 1'b0 : febe_bad_q;
  assign p_mis       = (kind == SLOT_PAR)  && (bit_in != prev_par_q);
  assign cp_mis      = (kind == SLOT_CPAR) && (bit_in != prev_par_q);
  assign febe_mis    = (kind == SLOT_FEBE) && !bit_in;

  assign p_hit    = step && (kind == SLOT_PAR) && (cur.sf == SF_W'(PAR_SF_B))
                 && prev_ok_q && (p_base || p_mis);
  assign cp_hit   = step && (kind == SLOT_CPAR) && (cur.blk == BLK_W'(LAST_C_BLK))
                 && prev_ok_q && (cp_base || cp_mis);
  assign febe_hit = step && (kind == SLOT_FEBE) && (cur.blk == BLK_W'(LAST_C_BLK))
                 && (febe_base || febe_mis);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= 1'b0;
      prev_par_q <= 1'b0;
      prev_ok_q  <= 1'b0;
      p_bad_q    <= 1'b0;
      cp_bad_q   <= 1'b0;
      febe_bad_q <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      err_pulse <= p_hit || cp_hit;
      if (step) begin
        acc_q      <= acc_n;
        p_bad_q    <= p_base    || p_mis;
        cp_bad_q   <= cp_base   || cp_mis;
        febe_bad_q <= febe_base || febe_mis;
      end
      if (oof || realign) begin
        prev_ok_q <= 1'b0;
      end else if (step && frame_end) begin
        prev_ok_q  <= 1'b1;
        prev_par_q <= acc_n;
      end
    end
  end

endmodule

// File: rtl/ds3dm_sat_counter.sv
module ds3dm_sat_counter
  import ds3dm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic [W-1:0] held
);

  localparam logic [W-1:0] TOP = '1;

  logic [31:0] wide_n;
  logic [W-1:0] nxt;

  assign wide_n = sat_step(32'(count), inc, 32'(TOP));
  assign nxt    = wide_n[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      held  <= '0;
    end else if (clr) begin
      held  <= nxt;
      count <= '0;
    end else begin
      count <= nxt;
    end
  end

endmodule

// File: rtl/ds3_demux_mon.sv
module ds3_demux_mon
  import ds3dm_pkg::*;
#(
  parameter int TRIB_BITS = 12,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             sof,
  input  logic             oof,
  input  logic             rd_clr,
  output logic [6:0]       trib_data,
  output logic [6:0]       trib_vld,
  output logic             err_pulse,
  output logic [CNT_W-1:0] p_err_cnt,
  output logic [CNT_W-1:0] cp_err_cnt,
  output logic [CNT_W-1:0] febe_cnt
);

  frame_pos_t cur;
  logic       in_frame, frame_end, realign, step;
  slot_e      kind;
  logic [LANE_W-1:0] lane;
  logic       p_hit, cp_hit, febe_hit;
  logic       stuff_now;
  logic [NUM_CNT-1:0] ev;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_live;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_held;

  ds3dm_position #(.TRIB_BITS(TRIB_BITS)) u_pos (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sof(sof), .oof(oof),
    .cur(cur), .in_frame(in_frame), .frame_end(frame_end), .realign(realign)
  );

  assign step      = bit_en && in_frame;
  assign kind      = classify(cur);
  assign lane      = lane_of(cur);
  assign stuff_now = step && (kind == SLOT_STUFF);

  ds3dm_demux u_demux (
    .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .lane(lane),
    .bit_in(bit_in), .trib_data(trib_data), .trib_vld(trib_vld)
  );

  ds3dm_parity_mon u_mon (
    .clk(clk), .rst_n(rst_n), .step(step), .oof(oof), .realign(realign),
    .frame_end(frame_end), .kind(kind), .cur(cur), .bit_in(bit_in),
    .p_hit(p_hit), .cp_hit(cp_hit), .febe_hit(febe_hit), .err_pulse(err_pulse)
  );

  assign ev = {febe_hit, cp_hit, p_hit};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    ds3dm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(ev[g]), .clr(rd_clr),
      .count(cnt_live[g]), .held(cnt_held[g])
    );
  end

  assign p_err_cnt  = cnt_held[0];
  assign cp_err_cnt = cnt_held[1];
  assign febe_cnt   = cnt_held[2];

endmodule

// File: rtl/ds3dm_checker.sv
module ds3dm_checker
  import ds3dm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          oof,
  input logic                          rd_clr,
  input logic [6:0]                    trib_vld,
  input logic                          stuff_now,
  input logic                          err_pulse,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_live
);

  localparam logic [CNT_W-1:0] TOP = '1;

  assert_vld_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trib_vld));

  assert_stuff_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |=> (trib_vld == '0));

  assert_oof_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oof |=> (trib_vld == '0));

  assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    assert_cnt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (oof && !rd_clr) |=> $stable(cnt_live[g]));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_live[g] == TOP && !rd_clr) |=> (cnt_live[g] == TOP));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> (cnt_live[g] == '0));

    // R3 R5: a counter never grows by more than one per clock
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr |=> (cnt_live[g] == $past(cnt_live[g])
                   || cnt_live[g] == $past(cnt_live[g]) + 1'b1));
  end

endmodule

bind ds3_demux_mon ds3dm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oof(oof), .rd_clr(rd_clr),
  .trib_vld(trib_vld), .stuff_now(stuff_now), .err_pulse(err_pulse),
  .cnt_live(cnt_live)
);

// File: tb/ds3_demux_mon_test.sv
module ds3_demux_mon_test;

  localparam int CLK_PERIOD = 10;
  localparam int TB_BITS    = 2;
  localparam int CW         = 4;
  localparam int MAXC       = 15;
  localparam int BLK_LEN    = 1 + 7 * TB_BITS;

  logic clk = 1'b0;
  logic rst_n, bit_en, bit_in, sof, oof, rd_clr;
  logic [6:0] trib_data, trib_vld;
  logic err_pulse;
  logic [CW-1:0] p_err_cnt, cp_err_cnt, febe_cnt;

  ds3_demux_mon #(.TRIB_BITS(TB_BITS), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .sof(sof),
    .oof(oof), .rd_clr(rd_clr), .trib_data(trib_data), .trib_vld(trib_vld),
    .err_pulse(err_pulse), .p_err_cnt(p_err_cnt), .cp_err_cnt(cp_err_cnt),
    .febe_cnt(febe_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int exp_p = 0, exp_cp = 0, exp_febe = 0;
  bit prev_valid = 0, prev_par = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit info_val(int seed, int sf, int blk, int b);
    return ((seed * 7 + sf * 13 + blk * 5 + b * 3) % 11) < 5;
  endfunction

  function automatic int sat(int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic run_frame(int seed, bit bad_p, bit bad_cp, logic [2:0] febe,
                           bit oof_on, bit gaps, int cut, string req);
    int route_err = 0, idle_err = 0, pulses = 0, sent = 0, exp_pulses;
    bit par = 0, stop = 0, val;
    for (int sf = 0; sf < 7 && !stop; sf++)
      for (int blk = 0; blk < 8 && !stop; blk++)
        for (int b = 0; b < BLK_LEN && !stop; b++) begin
          int exp_t = -1;
          if (cut > 0 && sent == cut) begin
            stop = 1;
          end else begin
            if (b == 0) begin
              if (blk == 0 && (sf == 2 || sf == 3)) val = prev_par ^ bad_p;
              else if (blk % 2 == 0 && blk > 0 && sf == 2) val = prev_par ^ bad_cp;
              else if (blk % 2 == 0 && blk > 0 && sf == 3) val = febe[blk/2 - 1];
              else val = (blk % 2);
            end else begin
              val = info_val(seed, sf, blk, b);
              par ^= val;
              if (!(blk == 7 && b - 1 == sf)) exp_t = (b - 1) % 7;
            end
            if (oof_on) exp_t = -1;
            @(negedge clk);
            bit_in = val; bit_en = 1'b1; oof = oof_on;
            sof = (sf == 0 && blk == 0 && b == 0);
            @(posedge clk); #1;
            if (err_pulse) pulses++;
            if (exp_t < 0) begin
              if (trib_vld != 7'd0) route_err++;
            end else if (trib_vld != (7'd1 << exp_t) || trib_data[exp_t] != val) begin
              route_err++;
            end
            sent++;
            if (gaps && (b % 4 == 1)) begin
              @(negedge clk);
              bit_en = 1'b0; sof = 1'b0;
              @(posedge clk); #1;
              if (trib_vld != 7'd0) idle_err++;
              if (err_pulse) pulses++;
            end
          end
        end
    @(negedge clk);
    bit_en = 1'b0; sof = 1'b0; oof = 1'b0;
    check(route_err == 0, req, route_err, 0);
    if (gaps) check(idle_err == 0, "R11 idle clocks", idle_err, 0);
    exp_pulses = 0;
    if (!oof_on && cut == 0) begin
      if (prev_valid) begin
        exp_p  = sat(exp_p + bad_p);
        exp_cp = sat(exp_cp + bad_cp);
        exp_pulses = int'(bad_p) + int'(bad_cp);
      end
      if (febe != 3'b111) exp_febe = sat(exp_febe + 1);
    end
    check(pulses == exp_pulses, "R6 err_pulse count", pulses, exp_pulses);
    prev_valid = !oof_on && cut == 0;
    prev_par   = par;
  endtask

  task automatic read_counts(string req);
    @(negedge clk);
    bit_en = 1'b0; sof = 1'b0; rd_clr = 1'b1;
    @(posedge clk); #1;
    rd_clr = 1'b0;
    check(int'(p_err_cnt) == exp_p, {req, " R3 P count"}, int'(p_err_cnt), exp_p);
    check(int'(cp_err_cnt) == exp_cp, {req, " R4 CP count"}, int'(cp_err_cnt), exp_cp);
    check(int'(febe_cnt) == exp_febe, {req, " R5 FEBE count"}, int'(febe_cnt), exp_febe);
    exp_p = 0; exp_cp = 0; exp_febe = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; sof = 1'b0; oof = 1'b0; rd_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(trib_vld == 7'd0 && !err_pulse, "R8 reset outputs", int'(trib_vld), 0);
    check(p_err_cnt == '0 && cp_err_cnt == '0 && febe_cnt == '0, "R8 reset counts",
          int'(p_err_cnt) + int'(cp_err_cnt) + int'(febe_cnt), 0);

    // R10: bits before the first sof are not delivered
    begin
      int pre_err = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); bit_en = 1'b1; bit_in = i[0]; sof = 1'b0;
        @(posedge clk); #1;
        if (trib_vld != 7'd0) pre_err++;
      end
      check(pre_err == 0, "R10 before first sof", pre_err, 0);
    end

    // First frame: parity errors injected but not checked (R3 R4)
    run_frame(1, 1, 1, 3'b111, 0, 0, 0, "R1 R2 first frame routing");
    run_frame(2, 0, 0, 3'b111, 0, 0, 0, "R1 R2 clean frame");
    run_frame(3, 1, 0, 3'b111, 0, 0, 0, "R1 R2 P error frame");
    run_frame(4, 0, 1, 3'b101, 0, 0, 0, "R1 R2 CP error frame");
    run_frame(5, 1, 1, 3'b000, 0, 1, 0, "R11 R1 frame with gaps");
    read_counts("first readout");
    read_counts("R8 second readout zero");

    // R9: out-of-frame freezes everything
    run_frame(6, 1, 1, 3'b000, 1, 0, 0, "R9 no strobes while oof");
    run_frame(7, 1, 0, 3'b011, 0, 0, 0, "R9 frame after oof");
    read_counts("R9 after oof");

    // R10: truncated frame then realign
    run_frame(8, 0, 0, 3'b111, 0, 0, 100, "R10 truncated frame");
    run_frame(9, 0, 1, 3'b111, 0, 0, 0, "R10 realigned frame");
    run_frame(10, 1, 0, 3'b111, 0, 0, 0, "R10 second frame after realign");
    read_counts("R10 after realign");

    // R7: saturation
    for (int f = 0; f < 18; f++)
      run_frame(20 + f, 0, 1, 3'b000, 0, 0, 0, "R1 R2 saturation frames");
    check(exp_cp == MAXC, "R7 model reaches top", exp_cp, MAXC);
    read_counts("R7 saturated");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule